// File: doc/BRIEF.md
# Flyback Conversion Mode Controller

This block picks the power-conversion mode of a resonant flyback converter once per switching cycle. A switching timer pulses `cyc_start` in the clock the primary switch turns on and `on_end` in the clock it turns off. The block watches two current-sense comparator flags and a collector over-voltage flag at fixed clock offsets from turn-on. From them it decides whether the converter runs light (Standby), steady (Normal), current-limited (Overload), or in a protective retry loop (Foldback, then a full-power Burst).

It drives three things. The first is an early-terminate request that ends the on-period when over-current is seen outside the blanking window. The second is an on-time ceiling in clocks. The third is an off-time extension in clocks. The switching timer applies both limits to the cycles that follow. The mode decision for a finished cycle is made at the next `cyc_start` and shows on the outputs one clock later. All pins are plain control and status levels or strobes. There is no data stream and no back-pressure.

Top module: `flyback_mode_ctrl`

## Requirements
- R1: After reset, `mode` is Standby (code 0), `term_req` is 0, `on_limit` is ON_FULL (200) and `off_ext` is 0. The mode codes are Standby 0, Normal 1, Overload 2, Foldback 3 and Burst 4.
- R2: Elapsed time is 0 in the clock where `cyc_start` is high and counts up by one per clock after it. `cs_high_hit` has no effect while elapsed time is below 4 clocks: it does not raise `term_req` and it does not change the mode.
- R3: `cs_high_hit` during the on-period at elapsed time 4 or more sets `term_req` from the next clock until the next `cyc_start`. If elapsed time is 26 or more, the next decision moves Standby or Normal to Overload, and Overload stays in Overload.
- R4: An over-current trip at elapsed time from 4 to 25 is an early trip. It moves Standby, Normal or Overload to Foldback at the next decision.
- R5: `col_ovp` is high at `on_end` in four consecutive cycles → Foldback at the next decision. An `on_end` with `col_ovp` low restarts the run.
- R6: `cs_low_hit` is sampled at elapsed time 19, and 1 means demand. In Standby with no demand, the on-limit drops by ON_STEP (20) per cycle down to ON_MIN (20). After that, the off-extension grows by OFF_STEP (256) per cycle up to OFF_MAX (1920).
- R7: In Standby with demand, the off-extension first falls by OFF_STEP per cycle down to 0. The on-limit then rises by ON_STEP, and reaching ON_FULL moves the mode to Normal.
- R8: Normal without demand moves to Standby with on-limit ON_FULL and off-extension 0. Overload without a trip moves to Normal.
- R9: Foldback drives on-limit FOLD_ON (20) and off-extension FOLD_OFF (896). It lasts FOLD_CYCLES (1024) cycles, then moves to Burst. Burst is entered from no other mode.
- R10: Burst drives on-limit ON_FULL and off-extension 0 for BURST_CYCLES (64) cycles. At the end it moves to Normal if its last cycle had no early trip, and to Foldback otherwise.
- R11: Mode and limits change only in the clock after a `cyc_start`. The first `cyc_start` after reset makes no decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_start | input | 1 | One-clock strobe at primary switch turn-on |
| on_end | input | 1 | One-clock strobe at the end of the on-period |
| cs_low_hit | input | 1 | Low-threshold current comparator, 1 = demand |
| cs_high_hit | input | 1 | Over-current comparator |
| col_ovp | input | 1 | Collector over-voltage comparator, read at `on_end` |
| mode | output | 3 | Current conversion mode code |
| term_req | output | 1 | Request to end the on-period early |
| on_limit | output | 8 | On-time ceiling in clocks |
| off_ext | output | 11 | Off-time extension in clocks |

## Verification
A long run of no-demand cycles drives Standby to its floor and ceiling, and a run of demand cycles walks it back up to Normal. Comparing the two shows that the off-time unwinds before the on-time grows. Over-current pulses are placed inside the blanking window, at exactly 26 clocks, and at 10 clocks. These separate an ignored pulse, a plain Overload and an early trip into Foldback. Collector over-voltage runs of three cycles and then four cycles show that only four in a row trigger Foldback. Two full Foldback/Burst loops, one that ends with an early trip and one without, show both exits from Burst.

// File: rtl/flyback_mode_pkg.sv
package flyback_mode_pkg;
  typedef enum logic [2:0] {
    MODE_STANDBY  = 3'd0,
    MODE_NORMAL   = 3'd1,
    MODE_OVERLOAD = 3'd2,
    MODE_FOLDBACK = 3'd3,
    MODE_BURST    = 3'd4
  } conv_mode_t;
endpackage

// File: rtl/flyback_cycle_sampler.sv
module flyback_cycle_sampler #(
  parameter int BLANK_CLK  = 4,
  parameter int SAMPLE_CLK = 19,
  parameter int EARLY_CLK  = 26
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cyc_start,
  input  logic on_end,
  input  logic cs_low_hit,
  input  logic cs_high_hit,
  output logic term_req,
  output logic trip_seen,
  output logic early_seen,
  output logic demand_seen
);
  localparam int EW = $clog2(EARLY_CLK + 2);

  logic [EW-1:0] elap_q;
  logic          on_q;
  logic          trip_now;

  // elap_q holds clocks since the last strobe whenever cyc_start is low
  assign trip_now = cs_high_hit && on_q && !cyc_start && (elap_q >= EW'(BLANK_CLK));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      elap_q      <= '0;
      on_q        <= 1'b0;
      term_req    <= 1'b0;
      trip_seen   <= 1'b0;
      early_seen  <= 1'b0;
      demand_seen <= 1'b0;
    end else if (cyc_start) begin
      elap_q      <= EW'(1);
      on_q        <= 1'b1;
      term_req    <= 1'b0;
      trip_seen   <= 1'b0;
      early_seen  <= 1'b0;
      demand_seen <= 1'b0;
    end else begin
      if (elap_q != '1) elap_q <= elap_q + EW'(1);
      if (on_end || trip_now) on_q <= 1'b0;
      if (trip_now) begin
        term_req  <= 1'b1;
        trip_seen <= 1'b1;
        if (elap_q < EW'(EARLY_CLK)) early_seen <= 1'b1;
      end
      if (elap_q == EW'(SAMPLE_CLK)) demand_seen <= cs_low_hit;
    end
  end

  // R2: inside the blanking window the terminate request cannot change
  p_blank_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cyc_start && elap_q < EW'(BLANK_CLK)) |=> $stable(term_req));

  // R3: an over-current hit past blanking during the on-period raises the request
  p_trip_term_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_high_hit && on_q && !cyc_start && elap_q >= EW'(BLANK_CLK)) |=> term_req);

  // R4: an early trip is always also a trip
  p_early_implies_trip_r4: assert property (@(posedge clk) disable iff (!rst_n)
    early_seen |-> trip_seen);
endmodule

// File: rtl/flyback_ovp_count.sv
module flyback_ovp_count #(
  parameter int OVP_RUN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic on_end,
  input  logic col_ovp,
  output logic ovp_hit
);
  localparam int RW = $clog2(OVP_RUN + 1);

  logic [RW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_q <= '0;
    else if (!enable) run_q <= '0;
    else if (on_end) begin
      if (!col_ovp)                   run_q <= '0;
      else if (run_q != RW'(OVP_RUN)) run_q <= run_q + RW'(1);
    end
  end

  assign ovp_hit = (run_q == RW'(OVP_RUN));

  // R5: the run count never passes the trigger length
  p_ovp_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= RW'(OVP_RUN));

  // R5: a clean end of on-time breaks the run
  p_ovp_break_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && on_end && !col_ovp) |=> !ovp_hit);
endmodule

// File: rtl/flyback_mode_fsm.sv
module flyback_mode_fsm
  import flyback_mode_pkg::*;
#(
  parameter int ON_FULL      = 200,
  parameter int ON_MIN       = 20,
  parameter int ON_STEP      = 20,
  parameter int OFF_MAX      = 1920,
  parameter int OFF_STEP     = 256,
  parameter int FOLD_ON      = 20,
  parameter int FOLD_OFF     = 896,
  parameter int FOLD_CYCLES  = 1024,
  parameter int BURST_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cyc_start,
  input  logic trip_seen,
  input  logic early_seen,
  input  logic demand_seen,
  input  logic ovp_hit,
  output conv_mode_t mode,
  output logic ovp_enable,
  output logic [$clog2(ON_FULL+1)-1:0] on_limit,
  output logic [$clog2(((OFF_MAX > FOLD_OFF) ? OFF_MAX : FOLD_OFF)+1)-1:0] off_ext
);
  localparam int ON_W    = $clog2(ON_FULL + 1);
  localparam int OFF_TOP = (OFF_MAX > FOLD_OFF) ? OFF_MAX : FOLD_OFF;
  localparam int OFF_W   = $clog2(OFF_TOP + 1);
  localparam int CNT_TOP = (FOLD_CYCLES > BURST_CYCLES) ? FOLD_CYCLES : BURST_CYCLES;
  localparam int CW      = (CNT_TOP > 2) ? $clog2(CNT_TOP) : 1;

  conv_mode_t     mode_q, mode_d;
  logic [ON_W-1:0]  son_q, son_d;
  logic [OFF_W-1:0] soff_q, soff_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             started_q;

  always_comb begin
    mode_d = mode_q;
    son_d  = son_q;
    soff_d = soff_q;
    cnt_d  = cnt_q;
    if (cyc_start && started_q) begin
      unique case (mode_q)
        MODE_STANDBY, MODE_NORMAL, MODE_OVERLOAD: begin
          if (early_seen || ovp_hit) begin
            mode_d = MODE_FOLDBACK;
            cnt_d  = '0;
          end else if (trip_seen) begin
            mode_d = MODE_OVERLOAD;
          end else if (mode_q == MODE_OVERLOAD) begin
            mode_d = MODE_NORMAL;
          end else if (mode_q == MODE_NORMAL) begin
            if (!demand_seen) begin
              mode_d = MODE_STANDBY;
              son_d  = ON_W'(ON_FULL);
              soff_d = '0;
            end
          end else if (demand_seen) begin
            if (soff_q != '0)
              soff_d = (int'(soff_q) > OFF_STEP) ? soff_q - OFF_W'(OFF_STEP) : '0;
            else if (int'(son_q) + ON_STEP >= ON_FULL) begin
              son_d  = ON_W'(ON_FULL);
              mode_d = MODE_NORMAL;
            end else
              son_d = son_q + ON_W'(ON_STEP);
          end else begin
            if (int'(son_q) > ON_MIN)
              son_d = (int'(son_q) > ON_MIN + ON_STEP) ? son_q - ON_W'(ON_STEP) : ON_W'(ON_MIN);
            else
              soff_d = (int'(soff_q) + OFF_STEP >= OFF_MAX) ? OFF_W'(OFF_MAX)
                                                           : soff_q + OFF_W'(OFF_STEP);
          end
        end
        MODE_FOLDBACK: begin
          if (cnt_q == CW'(FOLD_CYCLES - 1)) begin
            mode_d = MODE_BURST;
            cnt_d  = '0;
          end else cnt_d = cnt_q + CW'(1);
        end
        MODE_BURST: begin
          if (cnt_q == CW'(BURST_CYCLES - 1)) begin
            mode_d = early_seen ? MODE_FOLDBACK : MODE_NORMAL;
            cnt_d  = '0;
          end else cnt_d = cnt_q + CW'(1);
        end
        default: mode_d = MODE_STANDBY;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= MODE_STANDBY;
      son_q     <= ON_W'(ON_FULL);
      soff_q    <= '0;
      cnt_q     <= '0;
      started_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      son_q  <= son_d;
      soff_q <= soff_d;
      cnt_q  <= cnt_d;
      if (cyc_start) started_q <= 1'b1;
    end
  end

  always_comb begin
    unique case (mode_q)
      MODE_STANDBY: begin
        on_limit = son_q;
        off_ext  = soff_q;
      end
      MODE_FOLDBACK: begin
        on_limit = ON_W'(FOLD_ON);
        off_ext  = OFF_W'(FOLD_OFF);
      end
      default: begin
        on_limit = ON_W'(ON_FULL);
        off_ext  = '0;
      end
    endcase
  end

  assign mode       = mode_q;
  assign ovp_enable = (mode_q != MODE_FOLDBACK) && (mode_q != MODE_BURST);

  // R11: no mode change without a cycle strobe
  p_mode_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_start |=> $stable(mode_q));

  // R4: an early trip outside the retry loop lands in Foldback
  p_early_fold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_start && started_q && early_seen &&
     (mode_q == MODE_STANDBY || mode_q == MODE_NORMAL || mode_q == MODE_OVERLOAD))
    |=> mode_q == MODE_FOLDBACK);

  // R6: Standby limits stay inside their floor and ceiling
  p_sb_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_STANDBY) |-> (int'(son_q) >= ON_MIN && int'(soff_q) <= OFF_MAX));

  // R9: Burst is reached only from Foldback
  p_burst_entry_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != MODE_BURST && mode_q != MODE_FOLDBACK) |=> mode_q != MODE_BURST);

  // R10: Burst leaves only to Normal or Foldback
  p_burst_exit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_BURST) |=>
      (mode_q == MODE_BURST || mode_q == MODE_NORMAL || mode_q == MODE_FOLDBACK));
endmodule

// File: rtl/flyback_mode_ctrl.sv
module flyback_mode_ctrl
  import flyback_mode_pkg::*;
#(
  parameter int BLANK_CLK    = 4,
  parameter int SAMPLE_CLK   = 19,
  parameter int EARLY_CLK    = 26,
  parameter int OVP_RUN      = 4,
  parameter int ON_FULL      = 200,
  parameter int ON_MIN       = 20,
  parameter int ON_STEP      = 20,
  parameter int OFF_MAX      = 1920,
  parameter int OFF_STEP     = 256,
  parameter int FOLD_ON      = 20,
  parameter int FOLD_OFF     = 896,
  parameter int FOLD_CYCLES  = 1024,
  parameter int BURST_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cyc_start,
  input  logic on_end,
  input  logic cs_low_hit,
  input  logic cs_high_hit,
  input  logic col_ovp,
  output logic [2:0] mode,
  output logic term_req,
  output logic [$clog2(ON_FULL+1)-1:0] on_limit,
  output logic [$clog2(((OFF_MAX > FOLD_OFF) ? OFF_MAX : FOLD_OFF)+1)-1:0] off_ext
);
  logic       trip_seen, early_seen, demand_seen;
  logic       ovp_hit, ovp_enable;
  conv_mode_t mode_w;

  flyback_cycle_sampler #(
    .BLANK_CLK (BLANK_CLK),
    .SAMPLE_CLK(SAMPLE_CLK),
    .EARLY_CLK (EARLY_CLK)
  ) u_sampler (
    .clk        (clk),
    .rst_n      (rst_n),
    .cyc_start  (cyc_start),
    .on_end     (on_end),
    .cs_low_hit (cs_low_hit),
    .cs_high_hit(cs_high_hit),
    .term_req   (term_req),
    .trip_seen  (trip_seen),
    .early_seen (early_seen),
    .demand_seen(demand_seen)
  );

  flyback_ovp_count #(.OVP_RUN(OVP_RUN)) u_ovp (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (ovp_enable),
    .on_end (on_end),
    .col_ovp(col_ovp),
    .ovp_hit(ovp_hit)
  );

  flyback_mode_fsm #(
    .ON_FULL     (ON_FULL),
    .ON_MIN      (ON_MIN),
    .ON_STEP     (ON_STEP),
    .OFF_MAX     (OFF_MAX),
    .OFF_STEP    (OFF_STEP),
    .FOLD_ON     (FOLD_ON),
    .FOLD_OFF    (FOLD_OFF),
    .FOLD_CYCLES (FOLD_CYCLES),
    .BURST_CYCLES(BURST_CYCLES)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .cyc_start  (cyc_start),
    .trip_seen  (trip_seen),
    .early_seen (early_seen),
    .demand_seen(demand_seen),
    .ovp_hit    (ovp_hit),
    .mode       (mode_w),
    .ovp_enable (ovp_enable),
    .on_limit   (on_limit),
    .off_ext    (off_ext)
  );

  assign mode = mode_w;
endmodule

// File: tb/test_flyback_mode_ctrl.sv
`timescale 1ns/1ps
module test_flyback_mode_ctrl;
  localparam int ON_FULL = 200, ON_MIN = 20, OFF_MAX = 1920;
  localparam int FOLD_ON = 20, FOLD_OFF = 896, FOLD_N = 1024, BURST_N = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cyc_start = 1'b0, on_end = 1'b0, cs_low_hit = 1'b0, cs_high_hit = 1'b0, col_ovp = 1'b0;
  logic [2:0]  mode;
  logic        term_req;
  logic [7:0]  on_limit;
  logic [10:0] off_ext;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  flyback_mode_ctrl i_flyback_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .on_end(on_end),
    .cs_low_hit(cs_low_hit), .cs_high_hit(cs_high_hit), .col_ovp(col_ovp),
    .mode(mode), .term_req(term_req), .on_limit(on_limit), .off_ext(off_ext)
  );

  // behavioural reference model, one update per rising edge
  int m_e, m_mode, m_cnt, m_son, m_soff, m_ovp;
  bit m_on, m_term, m_trip, m_early, m_dem, m_started;

  always @(posedge clk) begin
    bit hit;
    int old_mode;
    if (!rst_n) begin
      m_e = 0; m_on = 0; m_term = 0; m_trip = 0; m_early = 0; m_dem = 0;
      m_started = 0; m_mode = 0; m_cnt = 0; m_son = ON_FULL; m_soff = 0; m_ovp = 0;
    end else begin
      hit = cs_high_hit && m_on && !cyc_start && (m_e >= 4);
      old_mode = m_mode;
      if (cyc_start && m_started) begin
        if (old_mode <= 2) begin
          if (m_early || m_ovp >= 4) begin m_mode = 3; m_cnt = 0; end
          else if (m_trip) m_mode = 2;
          else if (old_mode == 2) m_mode = 1;
          else if (old_mode == 1) begin
            if (!m_dem) begin m_mode = 0; m_son = ON_FULL; m_soff = 0; end
          end else if (m_dem) begin
            if (m_soff > 0) m_soff = (m_soff > 256) ? m_soff - 256 : 0;
            else if (m_son + 20 >= ON_FULL) begin m_son = ON_FULL; m_mode = 1; end
            else m_son += 20;
          end else begin
            if (m_son > ON_MIN) m_son = (m_son - 20 < ON_MIN) ? ON_MIN : m_son - 20;
            else m_soff = (m_soff + 256 > OFF_MAX) ? OFF_MAX : m_soff + 256;
          end
        end else if (old_mode == 3) begin
          m_cnt++;
          if (m_cnt == FOLD_N) begin m_mode = 4; m_cnt = 0; end
        end else begin
          m_cnt++;
          if (m_cnt == BURST_N) begin m_mode = m_early ? 3 : 1; m_cnt = 0; end
        end
      end
      if (old_mode >= 3) m_ovp = 0;
      else if (on_end) m_ovp = col_ovp ? ((m_ovp < 4) ? m_ovp + 1 : 4) : 0;
      if (cyc_start) begin
        m_started = 1; m_e = 1; m_on = 1; m_term = 0; m_trip = 0; m_early = 0; m_dem = 0;
      end else begin
        if (m_e == 19) m_dem = cs_low_hit;
        if (hit) begin m_term = 1; m_trip = 1; if (m_e < 26) m_early = 1; end
        if (on_end || hit) m_on = 0;
        if (m_e < 31) m_e++;
      end
    end
  end

  function automatic int exp_on(int md);
    return (md == 0) ? m_son : (md == 3) ? FOLD_ON : ON_FULL;
  endfunction
  function automatic int exp_off(int md);
    return (md == 0) ? m_soff : (md == 3) ? FOLD_OFF : 0;
  endfunction

  // R11: every clock the outputs match the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      n_chk++;
      if (int'(mode) != m_mode || term_req != m_term ||
          int'(on_limit) != exp_on(m_mode) || int'(off_ext) != exp_off(m_mode)) begin
        n_fail++;
        $display("FAIL %s/R11 t=%0t mode=%0d term=%0d on=%0d off=%0d expected mode=%0d term=%0d on=%0d off=%0d",
                 cur_req, $time, mode, term_req, on_limit, off_ext,
                 m_mode, m_term, exp_on(m_mode), exp_off(m_mode));
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(int len, int onl, bit dem, int hs, int hl, bit ovp);
    for (int k = 0; k < len; k++) begin
      @(negedge clk); #1;
      cyc_start   = (k == 0);
      on_end      = (k == onl);
      col_ovp     = ovp && (k == onl);
      cs_low_hit  = dem;
      cs_high_hit = (k >= hs) && (k < hs + hl);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R1 mode", int'(mode), 0);
    chk("R1 term_req", int'(term_req), 0);
    chk("R1 on_limit", int'(on_limit), ON_FULL);
    chk("R1 off_ext", int'(off_ext), 0);

    cur_req = "R6";
    repeat (25) cyc(40, 30, 0, 0, 0, 0);
    chk("R6 mode", int'(mode), 0);
    chk("R6 on_limit floor", int'(on_limit), ON_MIN);
    chk("R6 off_ext ceiling", int'(off_ext), OFF_MAX);

    cur_req = "R7";
    repeat (5) cyc(40, 30, 1, 0, 0, 0);
    chk("R7 off unwinds first", int'(off_ext), 896);
    chk("R7 on held at floor", int'(on_limit), ON_MIN);
    repeat (15) cyc(40, 30, 1, 0, 0, 0);
    chk("R7 reach Normal", int'(mode), 1);

    cur_req = "R2";
    cyc(40, 30, 1, 1, 3, 0);
    chk("R2 blanked term_req", int'(term_req), 0);
    cyc(40, 30, 1, 0, 0, 0);
    chk("R2 mode unchanged", int'(mode), 1);

    cur_req = "R3";
    cyc(40, 30, 1, 26, 2, 0);
    chk("R3 term_req", int'(term_req), 1);
    cyc(40, 30, 1, 0, 0, 0);
    chk("R3 Overload", int'(mode), 2);

    cur_req = "R8";
    cyc(40, 30, 0, 0, 0, 0);
    chk("R8 Overload to Normal", int'(mode), 1);
    cyc(40, 30, 0, 0, 0, 0);
    chk("R8 Normal to Standby", int'(mode), 0);
    chk("R8 Standby on_limit", int'(on_limit), ON_FULL);
    cyc(40, 30, 1, 0, 0, 0);
    cyc(40, 30, 1, 0, 0, 0);
    chk("R7 back to Normal", int'(mode), 1);

    cur_req = "R5";
    repeat (3) cyc(40, 30, 1, 0, 0, 1);
    cyc(40, 30, 1, 0, 0, 0);
    repeat (3) cyc(40, 30, 1, 0, 0, 1);
    chk("R5 three in a row no fold", int'(mode), 1);
    cyc(40, 30, 1, 0, 0, 1);
    chk("R5 still Normal", int'(mode), 1);

    cur_req = "R9";
    cyc(30, 20, 1, 0, 0, 0);
    chk("R5 Foldback", int'(mode), 3);
    chk("R9 fold on_limit", int'(on_limit), FOLD_ON);
    chk("R9 fold off_ext", int'(off_ext), FOLD_OFF);
    repeat (FOLD_N - 1) cyc(30, 20, 1, 0, 0, 0);
    chk("R9 Foldback length", int'(mode), 3);

    cur_req = "R10";
    cyc(30, 20, 1, 0, 0, 0);
    chk("R9 Burst entry", int'(mode), 4);
    chk("R10 burst on_limit", int'(on_limit), ON_FULL);
    chk("R10 burst off_ext", int'(off_ext), 0);
    repeat (BURST_N - 2) cyc(30, 20, 1, 0, 0, 0);
    cyc(30, 20, 1, 10, 2, 0);
    cyc(30, 20, 1, 0, 0, 0);
    chk("R10 overloaded burst back to Foldback", int'(mode), 3);
    repeat (FOLD_N - 1) cyc(30, 20, 1, 0, 0, 0);
    repeat (BURST_N) cyc(30, 20, 1, 0, 0, 0);
    cyc(40, 30, 1, 0, 0, 0);
    chk("R10 clean burst to Normal", int'(mode), 1);

    cur_req = "R4";
    cyc(40, 30, 1, 10, 2, 0);
    chk("R4 term_req", int'(term_req), 1);
    cyc(40, 30, 1, 0, 0, 0);
    chk("R4 early trip Foldback", int'(mode), 3);

    done = 1;
    report();
  end
endmodule